// File: doc/BRIEF.md
# Ring Timing Reference Selector

This block decides where one node of a two-fiber access ring takes its timing from. It watches a received synchronization status code and a signal-fail flag on each of the two line interfaces (east and west), plus a code and a fail flag for the external building clock. It picks one of four timing modes: external, line-timed from east, line-timed from west, or holdover. It also drives the status code sent out on each line interface.

Received codes only count once they have held the same value for several message periods. A line interface that is receiving the loop-back code is never used as a reference. The node advertises the loop-back code on the interface it is timed from, so neighbouring nodes cannot time from it and the ring cannot close a timing loop. Automatic switching on received codes needs both a messaging enable and an automatic-switching enable. Loss of the active reference always forces a fall back to holdover.

Code values are SQU=0 (traceable, usable), TLB=1 (timing looped back), IC=2 (internal clock) and ST3=3 (stratum-3 holdover). Mode values are HOLD=0, EXT=1, EAST=2 and WEST=3.

Top module: `ringRefSelect`

## Requirements
- R1: While reset is asserted, timingMode is HOLD (0) and both eastTxCode and westTxCode are IC (2).
- R2: With automatic switching on, if extEnable is high, extFail is low and the accepted external code is SQU (0), the mode becomes EXT (1) and both transmit codes are SQU (0), whatever the line interfaces report.
- R3: A line interface is eligible only when its fail flag is low and its accepted code is SQU (0). A line receiving TLB (1), IC or ST3 is never eligible. If external timing is not eligible, the single eligible line is chosen (EAST=2, WEST=3). When both lines are eligible, preferWest=1 picks WEST and preferWest=0 picks EAST.
- R4: In mode EAST, eastTxCode is TLB (1) and westTxCode is SQU (0). In mode WEST, westTxCode is TLB (1) and eastTxCode is SQU (0).
- R5: When the fail flag of the active reference rises, the mode leaves that reference one clock later. It goes to HOLD if no alternative is eligible, and it does so even while automatic switching is disabled.
- R6: A received code is accepted only after it has been sampled equal on STABLE_N (default 3) consecutive msgStrobe pulses. A code that holds for fewer pulses has no effect on the mode.
- R7: In mode HOLD, both transmit codes are IC (2) when stratum3 is low and ST3 (3) when stratum3 is high.
- R8: While msgEnable or autoEnable is low, changes in the accepted codes do not change the mode. Once both are high again, the mode moves to the code-based choice one clock later.
- R9: The mode and both transmit codes change on the same clock edge, the edge after the accepted code or fail flag that caused the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgStrobe | input | 1 | One-cycle pulse per message period; the received codes are sampled on it |
| eastCode | input | 2 | Code received on the east line |
| eastFail | input | 1 | East line signal fail |
| westCode | input | 2 | Code received on the west line |
| westFail | input | 1 | West line signal fail |
| extCode | input | 2 | Status code of the building clock input |
| extFail | input | 1 | Building clock input fail |
| extEnable | input | 1 | External timing is configured |
| preferWest | input | 1 | Tie-break between two eligible lines: 1 picks west |
| stratum3 | input | 1 | Clock module is stratum-3 grade (holdover sends ST3) |
| msgEnable | input | 1 | Synchronization messaging enable |
| autoEnable | input | 1 | Automatic reference switching enable |
| timingMode | output | 2 | Selected timing mode |
| eastTxCode | output | 2 | Code sent on the east line |
| westTxCode | output | 2 | Code sent on the west line |

## Verification
A new code is accepted on the clock edge that samples the third equal strobe. The mode and transmit registers follow on the next edge, so the bench drives each strobe as a single-cycle pulse between falling edges. It waits one more falling edge after the last pulse and samples there. A fail flag changed at a falling edge acts through one register, so its result is read at the next falling edge. The short-run case samples after only two strobes, where the old mode must still hold. The disabled case samples after a full qualification, where the accepted code has changed but the mode must not.

// File: rtl/ringRefPkg.sv
package ringRefPkg;
  typedef enum logic [1:0] {
    CODE_SQU = 2'd0,
    CODE_TLB = 2'd1,
    CODE_IC  = 2'd2,
    CODE_ST3 = 2'd3
  } syncCode_t;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_EXT  = 2'd1,
    MODE_EAST = 2'd2,
    MODE_WEST = 2'd3
  } timingMode_t;

  // source slots in the qualified-code array
  localparam int SRC_EAST = 0;
  localparam int SRC_WEST = 1;
  localparam int SRC_EXT  = 2;
  localparam int NUM_SRC  = 3;

  typedef struct packed {
    logic        load;
    timingMode_t mode;
  } ctlStrobe_t;
endpackage

// File: rtl/refDatapath.sv
module refDatapath
  import ringRefPkg::*;
#(
  parameter int STABLE_N = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     msgStrobe,
  input  logic [NUM_SRC-1:0][1:0]  rawCode,
  input  logic                     stratum3,
  input  ctlStrobe_t               ctl,
  output logic [NUM_SRC-1:0][1:0]  qualCode,
  output timingMode_t              modeQ,
  output syncCode_t                eastTx,
  output syncCode_t                westTx
);
  localparam int CNT_W = $clog2(STABLE_N + 1);

  // per-source persistence filter
  for (genvar g = 0; g < NUM_SRC; g++) begin : gQual
    logic [1:0]       cand;
    logic [CNT_W-1:0] runCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cand        <= CODE_IC;
        runCnt      <= '0;
        qualCode[g] <= CODE_IC;
      end else if (msgStrobe) begin
        if (rawCode[g] != cand) begin
          cand   <= rawCode[g];
          runCnt <= CNT_W'(1);
        end else if (runCnt < CNT_W'(STABLE_N)) begin
          runCnt <= runCnt + CNT_W'(1);
          if (runCnt == CNT_W'(STABLE_N - 1)) qualCode[g] <= rawCode[g];
        end
      end
    end

    AST_ACCEPT_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(qualCode[g]) |-> $past(msgStrobe)); // R6
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      runCnt <= CNT_W'(STABLE_N)); // R6
  end

  // mode and transmit code registers, loaded together
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_HOLD;
      eastTx <= CODE_IC;
      westTx <= CODE_IC;
    end else if (ctl.load) begin
      modeQ <= ctl.mode;
      unique case (ctl.mode)
        MODE_EXT: begin
          eastTx <= CODE_SQU;
          westTx <= CODE_SQU;
        end
        MODE_EAST: begin
          eastTx <= CODE_TLB;
          westTx <= CODE_SQU;
        end
        MODE_WEST: begin
          eastTx <= CODE_SQU;
          westTx <= CODE_TLB;
        end
        default: begin
          eastTx <= stratum3 ? CODE_ST3 : CODE_IC;
          westTx <= stratum3 ? CODE_ST3 : CODE_IC;
        end
      endcase
    end
  end

  AST_TLB_ON_EAST: assert property (@(posedge clk) disable iff (!rstN)
    modeQ == MODE_EAST |-> (eastTx == CODE_TLB && westTx == CODE_SQU)); // R4
  AST_TLB_ON_WEST: assert property (@(posedge clk) disable iff (!rstN)
    modeQ == MODE_WEST |-> (westTx == CODE_TLB && eastTx == CODE_SQU)); // R4
  AST_HOLD_TX: assert property (@(posedge clk) disable iff (!rstN)
    modeQ == MODE_HOLD |-> (eastTx inside {CODE_IC, CODE_ST3} && eastTx == westTx)); // R7
endmodule

// File: rtl/refControl.sv
module refControl
  import ringRefPkg::*;
(
  input  logic [NUM_SRC-1:0][1:0] qualCode,
  input  logic                    eastFail,
  input  logic                    westFail,
  input  logic                    extFail,
  input  logic                    extEnable,
  input  logic                    preferWest,
  input  logic                    msgEnable,
  input  logic                    autoEnable,
  input  timingMode_t             curMode,
  output ctlStrobe_t              ctl
);
  logic        eastOk, westOk, extOk, autoOn, curLost;
  timingMode_t target, nextMode;

  always_comb begin
    eastOk = !eastFail && qualCode[SRC_EAST] == CODE_SQU;
    westOk = !westFail && qualCode[SRC_WEST] == CODE_SQU;
    extOk  = extEnable && !extFail && qualCode[SRC_EXT] == CODE_SQU;
    autoOn = msgEnable && autoEnable;

    if (extOk)                 target = MODE_EXT;
    else if (eastOk && westOk) target = preferWest ? MODE_WEST : MODE_EAST;
    else if (eastOk)           target = MODE_EAST;
    else if (westOk)           target = MODE_WEST;
    else                       target = MODE_HOLD;

    curLost = (curMode == MODE_EXT  && (extFail || !extEnable)) ||
              (curMode == MODE_EAST && eastFail) ||
              (curMode == MODE_WEST && westFail);

    if (autoOn)       nextMode = target;
    else if (curLost) nextMode = MODE_HOLD;
    else              nextMode = curMode;

    ctl.mode = nextMode;
    ctl.load = (nextMode != curMode) || (nextMode == MODE_HOLD);
  end
endmodule

// File: rtl/ringRefSelect.sv
module ringRefSelect
  import ringRefPkg::*;
#(
  parameter int STABLE_N = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msgStrobe,
  input  logic [1:0] eastCode,
  input  logic       eastFail,
  input  logic [1:0] westCode,
  input  logic       westFail,
  input  logic [1:0] extCode,
  input  logic       extFail,
  input  logic       extEnable,
  input  logic       preferWest,
  input  logic       stratum3,
  input  logic       msgEnable,
  input  logic       autoEnable,
  output logic [1:0] timingMode,
  output logic [1:0] eastTxCode,
  output logic [1:0] westTxCode
);
  logic [NUM_SRC-1:0][1:0] rawCode, qualCode;
  ctlStrobe_t              ctl;
  timingMode_t             modeQ;
  syncCode_t               eastTx, westTx;

  assign rawCode[SRC_EAST] = eastCode;
  assign rawCode[SRC_WEST] = westCode;
  assign rawCode[SRC_EXT]  = extCode;

  refDatapath #(.STABLE_N(STABLE_N)) uData (
    .clk(clk), .rstN(rstN), .msgStrobe(msgStrobe), .rawCode(rawCode),
    .stratum3(stratum3), .ctl(ctl), .qualCode(qualCode),
    .modeQ(modeQ), .eastTx(eastTx), .westTx(westTx)
  );

  refControl uCtrl (
    .qualCode(qualCode), .eastFail(eastFail), .westFail(westFail),
    .extFail(extFail), .extEnable(extEnable), .preferWest(preferWest),
    .msgEnable(msgEnable), .autoEnable(autoEnable), .curMode(modeQ), .ctl(ctl)
  );

  assign timingMode = modeQ;
  assign eastTxCode = eastTx;
  assign westTxCode = westTx;

  AST_NO_TLB_EAST_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_EAST && $past(modeQ) != MODE_EAST) |-> $past(qualCode[SRC_EAST]) == CODE_SQU); // R3
  AST_NO_TLB_WEST_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_WEST && $past(modeQ) != MODE_WEST) |-> $past(qualCode[SRC_WEST]) == CODE_SQU); // R3
  AST_EAST_FAIL_LEAVE: assert property (@(posedge clk) disable iff (!rstN)
    eastFail |=> modeQ != MODE_EAST); // R5
  AST_WEST_FAIL_LEAVE: assert property (@(posedge clk) disable iff (!rstN)
    westFail |=> modeQ != MODE_WEST); // R5
endmodule

// File: tb/tb_ringRefSelect.sv
module tb_ringRefSelect;
  logic clk = 0;
  logic rstN = 0;
  logic msgStrobe = 0;
  logic [1:0] eastCode = 2, westCode = 2, extCode = 0;
  logic eastFail = 0, westFail = 0, extFail = 0, extEnable = 0, preferWest = 0;
  logic stratum3 = 0, msgEnable = 1, autoEnable = 1;
  logic [1:0] timingMode, eastTxCode, westTxCode;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  ringRefSelect dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) msgStrobe = 1;
      @(negedge clk) msgStrobe = 0;
    end
  endtask

  // expected mode from the requirements (automatic switching on)
  function automatic int expMode(int ec, int wc, bit ef, bit wf, bit xen, bit xf, bit pw);
    bit eOk = !ef && ec == 0;
    bit wOk = !wf && wc == 0;
    if (xen && !xf) return 1;
    if (eOk && wOk) return pw ? 3 : 2;
    if (eOk) return 2;
    if (wOk) return 3;
    return 0;
  endfunction

  function automatic int expTx(int mode, bit isEast, bit s3);
    case (mode)
      1: return 0;
      2: return isEast ? 1 : 0;
      3: return isEast ? 0 : 1;
      default: return s3 ? 3 : 2;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset mode", timingMode, 0);
    check("R1", "reset east tx", eastTxCode, 2);
    check("R1", "reset west tx", westTxCode, 2);
    @(negedge clk) rstN = 1;

    // near-exhaustive sweep; external code held at SQU throughout
    for (int ec = 0; ec < 4; ec++) begin
      for (int wc = 0; wc < 4; wc++) begin
        for (int b = 0; b < 64; b++) begin
          int m;
          eastCode = 2'(ec); westCode = 2'(wc);
          eastFail = b[0]; westFail = b[1]; extEnable = b[2];
          extFail = b[3]; preferWest = b[4]; stratum3 = b[5];
          pulses(3);
          @(negedge clk);
          m = expMode(ec, wc, b[0], b[1], b[2], b[3], b[4]);
          // R2 R3 external priority and line eligibility
          check(m == 1 ? "R2" : "R3", "sweep mode", timingMode, m);
          // R4 R7 transmit codes
          check(m == 0 ? "R7" : "R4", "sweep east tx", eastTxCode, expTx(m, 1, b[5]));
          check(m == 0 ? "R7" : "R4", "sweep west tx", westTxCode, expTx(m, 0, b[5]));
        end
      end
    end

    // R6 qualification: establish east, try short runs
    @(negedge clk);
    eastFail = 0; westFail = 0; extEnable = 0; extFail = 0; preferWest = 0; stratum3 = 0;
    eastCode = 0; westCode = 1;
    pulses(3); @(negedge clk);
    check("R6", "east established", timingMode, 2);
    eastCode = 1;
    pulses(2); @(negedge clk);
    check("R6", "two strobes of TLB ignored", timingMode, 2);
    eastCode = 0;
    pulses(1); eastCode = 1; pulses(2); @(negedge clk);
    check("R6", "interrupted run ignored", timingMode, 2);
    pulses(1);
    check("R9", "mode before update edge", timingMode, 2);
    @(negedge clk);
    check("R6", "third strobe accepted", timingMode, 0);
    check("R9", "east tx same edge", eastTxCode, 2);

    // R8 gating: back to east, then disable and change codes
    eastCode = 0; westCode = 0;
    pulses(3); @(negedge clk);
    check("R8", "east before disable", timingMode, 2);
    autoEnable = 0; eastCode = 1;
    pulses(3); @(negedge clk); @(negedge clk);
    check("R8", "auto off holds mode", timingMode, 2);
    check("R8", "auto off holds east tx", eastTxCode, 1);
    autoEnable = 1; msgEnable = 0;
    @(negedge clk); @(negedge clk);
    check("R8", "msg off holds mode", timingMode, 2);
    msgEnable = 1;
    @(negedge clk);
    check("R8", "re-enable moves to west", timingMode, 3);
    check("R4", "west tx TLB", westTxCode, 1);

    // R5 fail while disabled
    autoEnable = 0;
    @(negedge clk) westFail = 1;
    @(negedge clk);
    check("R5", "west fail forces hold", timingMode, 0);
    check("R7", "hold tx IC", eastTxCode, 2);
    westFail = 0;
    autoEnable = 1;
    @(negedge clk);
    check("R5", "west recovered", timingMode, 3);
    @(negedge clk) westFail = 1;
    @(negedge clk);
    check("R5", "auto fail no alternative", timingMode, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule